// File: doc/BRIEF.md
# Shared-Bus Priority Arbiter with Parking and Split Handover

This block decides which of several bus initiators owns a shared on-chip bus. Every initiator raises its own request line and receives its own grant line. The grant is registered and one-hot, and it moves only on cycles where the bus reports ready, so a transfer that is still in its data phase is never cut short. When several initiators ask at once, the one with the lowest index wins. When nobody asks, the grant parks on a parameter-selected default initiator. An encoded owner index drives the select of the central address and control multiplexer.

A slave may answer the current owner with a split. On a ready cycle with split asserted, the arbiter takes away every grant for one handover cycle. During that cycle the owner index points at the default initiator. It also blocks the split initiator from further arbitration. The blocked initiator becomes eligible again only after its own unsplit line is pulsed. Once the handover cycle is over, the next ready cycle hands the bus to the best remaining requester.

Top module: `shared_bus_arbiter`

## Requirements
- R1: After reset the grant vector is one-hot on the default initiator (parameter DEFAULT_MST), the owner index equals DEFAULT_MST and no initiator is blocked.
- R2: Outside a handover cycle exactly one grant bit is set, and the bit set is the one at position owner_o.
- R3: On a ready cycle the next grant goes to the eligible requester with the lowest index. An eligible requester has its request high and is not blocked.
- R4: On a ready cycle with no eligible requester, the next grant parks on DEFAULT_MST. Parking ignores blocking.
- R5: While ready_i is low, grant_o and owner_o keep their values, whatever req_i does.
- R6: A split (split_i high together with ready_i, outside a handover cycle) makes the next cycle a handover cycle: grant_o is all zero and owner_o equals DEFAULT_MST. split_i has no effect during a handover cycle.
- R7: A handover cycle lasts until the next ready cycle. On that cycle the grant goes to the best eligible requester, following R3 and R4.
- R8: The initiator that owned the bus at a split is blocked from winning until its unsplit_i bit is pulsed. The pulse takes effect on the clock edge where it is sampled, so the initiator can win from the following arbitration on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_MST | Request line per initiator, bit i = initiator i |
| unsplit_i | input | N_MST | One-cycle pulse per initiator that clears its split block |
| ready_i | input | 1 | Bus ready; grants may change only when high |
| split_i | input | 1 | Slave split response for the current owner's transfer |
| grant_o | output | N_MST | One-hot grant, all zero during a handover cycle |
| owner_o | output | $clog2(N_MST) | Index of the current owner; address/control mux select |

## Verification
A wrong priority pick or a lost block bit shows up at grant_o on the cycle right after the ready cycle that samples it, so every scenario checks exactly one edge after its stimulus. A stale handover phase shows as either an all-zero grant that never ends or a missing zero cycle after a split, and both are visible after one edge. The block bits themselves cannot be read. They show up as parking when the split initiator is the only one requesting, and as that initiator winning again once its unsplit pulse has been seen.

// File: rtl/arb_pkg.sv
package arb_pkg;

  // Bus ownership phase: normal ownership or the empty cycle after a split.
  typedef enum logic {
    PH_OWN = 1'b0,
    PH_GAP = 1'b1
  } arb_phase_e;

endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int N_MST       = 4,
  parameter int DEFAULT_MST = 1,
  localparam int IDX_W      = $clog2(N_MST)
) (
  input  logic [N_MST-1:0] elig_i,
  output logic [N_MST-1:0] pick_oh_o,
  output logic [IDX_W-1:0] pick_idx_o,
  output logic             any_o
);

  localparam logic [N_MST-1:0] DEF_OH = N_MST'(1) << DEFAULT_MST;

  // Isolate the lowest set bit (lowest index = highest priority).
  function automatic logic [N_MST-1:0] lowest_bit(input logic [N_MST-1:0] v);
    return v & (~v + N_MST'(1));
  endfunction

  // Encode a one-hot vector to its index.
  function automatic logic [IDX_W-1:0] oh_to_idx(input logic [N_MST-1:0] oh);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = 0; i < N_MST; i++) begin
      if (oh[i]) idx = idx | IDX_W'(i);
    end
    return idx;
  endfunction

  logic [N_MST-1:0] winner_oh;

  always_comb begin
    any_o     = |elig_i;
    winner_oh = lowest_bit(elig_i);
    pick_oh_o = any_o ? winner_oh : DEF_OH;
    pick_idx_o = oh_to_idx(pick_oh_o);
  end

endmodule

// File: rtl/arb_split_mask.sv
module arb_split_mask #(
  parameter int N_MST = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en_i,
  input  logic [N_MST-1:0] set_vec_i,
  input  logic [N_MST-1:0] clr_vec_i,
  output logic [N_MST-1:0] mask_o
);

  logic [N_MST-1:0] mask_q;

  // Per-initiator block bit; a new split wins over a simultaneous unsplit.
  for (genvar g = 0; g < N_MST; g++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q[g] <= 1'b0;
      end else if (set_en_i && set_vec_i[g]) begin
        mask_q[g] <= 1'b1;
      end else if (clr_vec_i[g]) begin
        mask_q[g] <= 1'b0;
      end
    end
  end

  assign mask_o = mask_q;

endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl
  import arb_pkg::*;
#(
  parameter int N_MST       = 4,
  parameter int DEFAULT_MST = 1,
  localparam int IDX_W      = $clog2(N_MST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ready_i,
  input  logic             split_i,
  input  logic [N_MST-1:0] pick_oh_i,
  input  logic [IDX_W-1:0] pick_idx_i,
  output logic [N_MST-1:0] grant_o,
  output logic [IDX_W-1:0] owner_o,
  output arb_phase_e       phase_o,
  output logic             split_evt_o
);

  localparam logic [N_MST-1:0] DEF_OH  = N_MST'(1) << DEFAULT_MST;
  localparam logic [IDX_W-1:0] DEF_IDX = IDX_W'(DEFAULT_MST);

  logic [N_MST-1:0] grant_q;
  logic [IDX_W-1:0] owner_q;
  arb_phase_e       phase_q;

  // A split counts only on a ready cycle while a real owner holds the bus.
  assign split_evt_o = split_i && ready_i && (phase_q == PH_OWN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_q <= DEF_OH;
      owner_q <= DEF_IDX;
      phase_q <= PH_OWN;
    end else if (split_evt_o) begin
      grant_q <= '0;
      owner_q <= DEF_IDX;
      phase_q <= PH_GAP;
    end else if (ready_i) begin
      grant_q <= pick_oh_i;
      owner_q <= pick_idx_i;
      phase_q <= PH_OWN;
    end
  end

  assign grant_o = grant_q;
  assign owner_o = owner_q;
  assign phase_o = phase_q;

endmodule

// File: rtl/shared_bus_arbiter.sv
module shared_bus_arbiter
  import arb_pkg::*;
#(
  parameter int N_MST       = 4,
  parameter int DEFAULT_MST = 1,
  localparam int IDX_W      = $clog2(N_MST)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MST-1:0] req_i,
  input  logic [N_MST-1:0] unsplit_i,
  input  logic             ready_i,
  input  logic             split_i,
  output logic [N_MST-1:0] grant_o,
  output logic [IDX_W-1:0] owner_o
);

  // Named internal events for the checker.
  logic [N_MST-1:0] mask_q;
  logic [N_MST-1:0] elig;
  logic [N_MST-1:0] pick_oh;
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any;
  logic             split_evt;
  arb_phase_e       phase_q;
  logic             in_gap;

  assign elig   = req_i & ~mask_q;
  assign in_gap = (phase_q == PH_GAP);

  arb_prio_pick #(.N_MST(N_MST), .DEFAULT_MST(DEFAULT_MST)) u_pick (
    .elig_i    (elig),
    .pick_oh_o (pick_oh),
    .pick_idx_o(pick_idx),
    .any_o     (pick_any)
  );

  arb_split_mask #(.N_MST(N_MST)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en_i (split_evt),
    .set_vec_i(grant_o),
    .clr_vec_i(unsplit_i),
    .mask_o   (mask_q)
  );

  arb_grant_ctrl #(.N_MST(N_MST), .DEFAULT_MST(DEFAULT_MST)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready_i    (ready_i),
    .split_i    (split_i),
    .pick_oh_i  (pick_oh),
    .pick_idx_i (pick_idx),
    .grant_o    (grant_o),
    .owner_o    (owner_o),
    .phase_o    (phase_q),
    .split_evt_o(split_evt)
  );

endmodule

// File: rtl/shared_bus_arbiter_chk.sv
module shared_bus_arbiter_chk #(
  parameter int N_MST       = 4,
  parameter int DEFAULT_MST = 1,
  localparam int IDX_W      = $clog2(N_MST)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MST-1:0] req_i,
  input logic             ready_i,
  input logic             split_i,
  input logic [N_MST-1:0] grant_o,
  input logic [IDX_W-1:0] owner_o,
  input logic [N_MST-1:0] mask_q,
  input logic             in_gap
);

  localparam logic [N_MST-1:0] DEF_OH = N_MST'(1) << DEFAULT_MST;

  logic split_taken;
  assign split_taken = split_i && ready_i && !in_gap;

  a_r2_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    !in_gap |-> ($countones(grant_o) == 1));

  a_r2_owner_matches: assert property (@(posedge clk) disable iff (!rst_n)
    !in_gap |-> grant_o[owner_o]);

  a_r5_hold_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_i |=> ($stable(grant_o) && $stable(owner_o)));

  a_r6_split_gap: assert property (@(posedge clk) disable iff (!rst_n)
    split_taken |=> (grant_o == '0) && (owner_o == IDX_W'(DEFAULT_MST)));

  a_r4_park_default: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && !split_taken && ((req_i & ~mask_q) == '0)) |=> (grant_o == DEF_OH));

  a_r8_blocked_loses: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_i && !split_taken && ((req_i & ~mask_q) != '0)) |=> ((grant_o & $past(mask_q)) == '0));

endmodule

bind shared_bus_arbiter shared_bus_arbiter_chk #(
  .N_MST(N_MST), .DEFAULT_MST(DEFAULT_MST)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .req_i  (req_i),
  .ready_i(ready_i),
  .split_i(split_i),
  .grant_o(grant_o),
  .owner_o(owner_o),
  .mask_q (mask_q),
  .in_gap (in_gap)
);

// File: tb/shared_bus_arbiter_bench.sv
module shared_bus_arbiter_bench;

  localparam int N   = 4;
  localparam int DEF = 1;
  localparam int IW  = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [N-1:0]  unsplit;
  logic          ready;
  logic          split;
  logic [N-1:0]  grant;
  logic [IW-1:0] owner;

  int tests  = 0;
  int failed = 0;

  always #2.5 clk = ~clk;

  shared_bus_arbiter #(.N_MST(N), .DEFAULT_MST(DEF)) u_shared_bus_arbiter (
    .clk(clk), .rst_n(rst_n), .req_i(req), .unsplit_i(unsplit),
    .ready_i(ready), .split_i(split), .grant_o(grant), .owner_o(owner)
  );

  // Bench-side model: scan from the top down so the last hit is the lowest index.
  function automatic logic [N-1:0] want_grant(input logic [N-1:0] elig);
    logic [N-1:0] r;
    r = N'(1) << DEF;
    for (int i = N - 1; i >= 0; i--) if (elig[i]) r = N'(1) << i;
    return r;
  endfunction

  // Drive on the falling edge, check just after the next rising edge.
  task automatic step();
    @(negedge clk);
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string tag, input logic [N-1:0] exp_g, input int exp_o);
    tests++;
    if (grant !== exp_g || owner !== IW'(exp_o)) begin
      failed++;
      $display("FAIL %s: grant=%b owner=%0d expected grant=%b owner=%0d",
               tag, grant, owner, exp_g, exp_o);
    end
  endtask

  function automatic int idx(input logic [N-1:0] oh);
    for (int i = 0; i < N; i++) if (oh[i]) return i;
    return 0;
  endfunction

  task automatic t_reset();
    check("R1 reset state", N'(1) << DEF, DEF);
  endtask

  task automatic t_priority();
    logic [N-1:0] pats [4] = '{4'b1100, 4'b1111, 4'b1000, 4'b0110};
    foreach (pats[k]) begin
      req = pats[k];
      step();
      check("R3 lowest index wins", want_grant(pats[k]), idx(want_grant(pats[k])));
    end
  endtask

  task automatic t_park();
    req = '0;
    step();
    check("R4 park on default", N'(1) << DEF, DEF);
  endtask

  task automatic t_ready_hold();
    req = 4'b0001;
    step();
    check("R3 single requester", 4'b0001, 0);
    ready = 1'b0;
    req = 4'b1000;
    step();
    check("R5 hold while not ready", 4'b0001, 0);
    req = 4'b0000;
    step();
    check("R5 no park while not ready", 4'b0001, 0);
    req = 4'b1000;
    ready = 1'b1;
    step();
    check("R5 move once ready", 4'b1000, 3);
  endtask

  task automatic t_split();
    req = 4'b0101;
    step();
    check("R3 before split", 4'b0001, 0);
    split = 1'b1;
    step();
    check("R6 handover cycle", 4'b0000, DEF);
    // Split during the gap with ready low: gap persists, split ignored.
    ready = 1'b0;
    step();
    check("R7 gap held while not ready", 4'b0000, DEF);
    split = 1'b0;
    ready = 1'b1;
    step();
    check("R7 handover to next requester", 4'b0100, 2);
    req = 4'b0001;
    step();
    check("R8 split initiator blocked", N'(1) << DEF, DEF);
    unsplit = 4'b0001;
    step();
    check("R8 unsplit edge still parked", N'(1) << DEF, DEF);
    unsplit = '0;
    step();
    check("R8 unblocked initiator wins", 4'b0001, 0);
  endtask

  task automatic t_split_to_park();
    req = 4'b0010;
    step();
    check("R3 default requests", 4'b0010, 1);
    split = 1'b1;
    step();
    check("R6 handover after default split", 4'b0000, DEF);
    split = 1'b0;
    req = 4'b0010;
    step();
    check("R4 park ignores block", 4'b0010, 1);
    req = 4'b0110;
    step();
    check("R8 blocked default skipped", 4'b0100, 2);
  endtask

  initial begin
    rst_n = 1'b0; req = '0; unsplit = '0; ready = 1'b1; split = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_priority();
    t_park();
    t_ready_hold();
    t_split();
    t_split_to_park();
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

  initial begin
    #100000;
    tests++;
    failed++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule